// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the address of the instruction being fetched in one register and works out, in every clock cycle, where fetch goes next. The decoder and the ALU of a single-cycle processor feed it a branch control, the ALU zero flag, a jump control, the 16-bit immediate field and the 26-bit jump target field. The register's output addresses the instruction memory directly.

Three candidate addresses are formed in parallel: the sequential address (current PC plus four), the branch target (sequential address plus the sign-extended immediate scaled by four) and the jump target (top four PC bits, the target field, two zero bits). A small priority selector picks one of them, and the register loads it on the rising clock edge that all other state of the processor shares. A synchronous reset returns fetch to address zero.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: With `br_en` and `jmp_en` both low, each rising edge sets `pc_o` to its previous value plus 4.
- R3: With `br_en` high, `alu_zero` high and `jmp_en` low, the next `pc_o` is the previous value plus 4 plus the immediate read as a signed 16-bit number and multiplied by 4 (negative immediates move fetch backwards).
- R4: With `br_en` high, `alu_zero` low and `jmp_en` low, the branch is not taken and `pc_o` advances by 4.
- R5: With `br_en` low and `jmp_en` low, the state of `alu_zero` has no effect: `pc_o` advances by 4.
- R6: With `jmp_en` high, the next `pc_o` keeps bits 31:28 of the current `pc_o`, takes bits 27:2 from the 26-bit `jtarget`, and has bits 1:0 equal to zero.
- R7: When `jmp_en` and a taken branch (`br_en` and `alu_zero` high) coincide, the jump wins and the R6 address is loaded.
- R8: After reset, bits 1:0 of `pc_o` are always zero.
- R9: All address arithmetic wraps modulo 2^32: plus 4 from 0xFFFFFFFC gives 0, and a negative branch offset below address 0 wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_en | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU result equals zero (operands compared equal) |
| jmp_en | input | 1 | Current instruction is an absolute jump |
| imm16 | input | 16 | Immediate field, branch word offset |
| jtarget | input | 26 | Jump target word field |
| pc_o | output | 32 | Current program counter, instruction memory address |

## Verification
The bench drives backward branches with negative immediates, where a design that zero-extends the offset would jump far forward instead of looping back. It steps from address zero with an immediate of -2 so that a branch wraps to 0xFFFFFFFC and the next sequential step wraps to 0, which catches a carry kept or a wrong width. It asserts jump and taken branch together, where a wrong priority loads the branch target, and it toggles the zero flag with no branch present and with a branch present but not taken, which exposes a select that ignores the branch control. A jump made from a high region checks that the upper four bits come from the current PC and not from the sequential address or from zeros.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Which candidate address the selector hands to the PC register.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } pc_src_e;

endpackage

// File: rtl/pcu_seq_adder.sv
module pcu_seq_adder #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] seq_o
);

  localparam int STEP = 1 << ALIGN_W;

  // One instruction forward; the carry out of the top bit is dropped.
  function automatic logic [ADDR_W-1:0] f_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP);
  endfunction

  assign seq_o = f_step(pc_i);

endmodule

// File: rtl/pcu_branch_calc.sv
module pcu_branch_calc #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] target_o
);

  localparam int EXT_W = ADDR_W - IMM_W - ALIGN_W;

  // Replicate the sign bit, then append zeros for the word scaling.
  function automatic logic [ADDR_W-1:0] f_offset(input logic [IMM_W-1:0] imm);
    return {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] f_target(input logic [ADDR_W-1:0] base,
                                                 input logic [IMM_W-1:0]  imm);
    return base + f_offset(imm);
  endfunction

  assign target_o = f_target(seq_i, imm_i);

endmodule

// File: rtl/pcu_jump_calc.sv
module pcu_jump_calc #(
  parameter int ADDR_W  = 32,
  parameter int TGT_W   = 26,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-TGT_W-ALIGN_W-1:0] pc_hi_i,
  input  logic [TGT_W-1:0]                tgt_i,
  output logic [ADDR_W-1:0]               target_o
);

  localparam int HI_W = ADDR_W - TGT_W - ALIGN_W;

  // Region bits stay, the field supplies the word address inside the region.
  function automatic logic [ADDR_W-1:0] f_region(input logic [HI_W-1:0]  hi,
                                                 input logic [TGT_W-1:0] tgt);
    return {hi, tgt, {ALIGN_W{1'b0}}};
  endfunction

  assign target_o = f_region(pc_hi_i, tgt_i);

endmodule

// File: rtl/pcu_src_select.sv
module pcu_src_select
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              br_en,
  input  logic              alu_zero,
  input  logic              jmp_en,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] branch_i,
  input  logic [ADDR_W-1:0] jump_i,
  output logic              take_branch_o,
  output pc_src_e           src_o,
  output logic [ADDR_W-1:0] next_o
);

  // The branch condition: control gated by the equality result.
  assign take_branch_o = br_en & alu_zero;

  always_comb begin
    if (jmp_en)             src_o = SRC_JUMP;
    else if (take_branch_o) src_o = SRC_BRANCH;
    else                    src_o = SRC_SEQ;
  end

  always_comb begin
    unique case (src_o)
      SRC_JUMP:   next_o = jump_i;
      SRC_BRANCH: next_o = branch_i;
      default:    next_o = seq_i;
    endcase
  end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 16,
  parameter int TGT_W    = 26,
  parameter int ALIGN_W  = 2,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_en,
  input  logic              alu_zero,
  input  logic              jmp_en,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  jtarget,
  output logic [ADDR_W-1:0] pc_o
);

  localparam int HI_W = ADDR_W - TGT_W - ALIGN_W;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] jmp_pc;
  logic [ADDR_W-1:0] nxt_pc;
  logic              take_branch;
  pc_src_e           src_sel;

  pcu_seq_adder #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) i_seq (
    .pc_i  (pc_q),
    .seq_o (seq_pc)
  );

  pcu_branch_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ALIGN_W(ALIGN_W)) i_br (
    .seq_i    (seq_pc),
    .imm_i    (imm16),
    .target_o (br_pc)
  );

  pcu_jump_calc #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .ALIGN_W(ALIGN_W)) i_jmp (
    .pc_hi_i  (pc_q[ADDR_W-1 -: HI_W]),
    .tgt_i    (jtarget),
    .target_o (jmp_pc)
  );

  pcu_src_select #(.ADDR_W(ADDR_W)) i_sel (
    .br_en         (br_en),
    .alu_zero      (alu_zero),
    .jmp_en        (jmp_en),
    .seq_i         (seq_pc),
    .branch_i      (br_pc),
    .jump_i        (jmp_pc),
    .take_branch_o (take_branch),
    .src_o         (src_sel),
    .next_o        (nxt_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= ADDR_W'(RESET_PC);
    else     pc_q <= nxt_pc;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int TGT_W   = 26,
  parameter int ALIGN_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              br_en,
  input logic              alu_zero,
  input logic              jmp_en,
  input logic [IMM_W-1:0]  imm16,
  input logic [TGT_W-1:0]  jtarget,
  input logic [ADDR_W-1:0] pc_o,
  input logic              take_branch,
  input pc_src_e           src_sel
);

  localparam int STEP = 1 << ALIGN_W;
  localparam int HI_W = ADDR_W - TGT_W - ALIGN_W;

  logic signed [ADDR_W-1:0] imm_wide;
  logic                     rst_q;

  assign imm_wide = $signed(imm16);

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_LOAD: assert (pc_o == '0); // R1
    end
  end

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && !br_en) |=> pc_o == $past(pc_o) + ADDR_W'(STEP)); // R2

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br_en && alu_zero && !jmp_en) |=>
      pc_o == $past(pc_o) + ADDR_W'(STEP) + ADDR_W'($past(imm_wide) * STEP)); // R3

  AST_BRANCH_SKIPPED: assert property (@(posedge clk) disable iff (rst)
    (br_en && !alu_zero && !jmp_en) |=> pc_o == $past(pc_o) + ADDR_W'(STEP)); // R4

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> (pc_o[ADDR_W-1 -: HI_W] == $past(pc_o[ADDR_W-1 -: HI_W])) &&
               (pc_o[ADDR_W-HI_W-1:ALIGN_W] == $past(jtarget))); // R6

  AST_JUMP_WINS: assert property (@(posedge clk) disable iff (rst)
    (jmp_en && take_branch) |-> src_sel == SRC_JUMP); // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_o[ALIGN_W-1:0] == '0); // R8

endmodule

bind next_pc_unit pcu_checker #(
  .ADDR_W (ADDR_W),
  .IMM_W  (IMM_W),
  .TGT_W  (TGT_W),
  .ALIGN_W(ALIGN_W)
) i_pcu_chk (
  .clk        (clk),
  .rst        (rst),
  .br_en      (br_en),
  .alu_zero   (alu_zero),
  .jmp_en     (jmp_en),
  .imm16      (imm16),
  .jtarget    (jtarget),
  .pc_o       (pc_o),
  .take_branch(take_branch),
  .src_sel    (src_sel)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        br_en;
  logic        alu_zero;
  logic        jmp_en;
  logic [15:0] imm16;
  logic [25:0] jtarget;
  logic [31:0] pc_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model_pc;

  always #2 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .clk     (clk),
    .rst     (rst),
    .br_en   (br_en),
    .alu_zero(alu_zero),
    .jmp_en  (jmp_en),
    .imm16   (imm16),
    .jtarget (jtarget),
    .pc_o    (pc_o)
  );

  // Monitor: one expected item per cycle, compared after the edge settles.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc_o !== e) begin
        failures++;
        $display("FAIL %s pc actual=%08h expected=%08h", t, pc_o, e);
      end
      checks++;
      if (pc_o[1:0] !== 2'b00) begin
        failures++;
        $display("FAIL R8 low bits actual=%0b expected=00", pc_o[1:0]);
      end
    end
  end

  task automatic drive_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; br_en = 1'b1; alu_zero = 1'b1; jmp_en = 1'b1;
    imm16 = 16'h1234; jtarget = 26'h2AAAAAA;
    model_pc = 32'h0;
    exp_q.push_back(model_pc);
    tag_q.push_back(tag);
  endtask

  // Driver: applies one cycle of controls and pushes the expected PC.
  task automatic drive(input logic b, input logic z, input logic j,
                       input logic [15:0] imm, input logic [25:0] tgt,
                       input string tag);
    int          off;
    logic [31:0] nxt;
    @(negedge clk);
    rst = 1'b0; br_en = b; alu_zero = z; jmp_en = j;
    imm16 = imm; jtarget = tgt;
    off = int'($signed(imm)) * 4;
    if (j)           nxt = {model_pc[31:28], tgt, 2'b00};
    else if (b && z) nxt = model_pc + 32'd4 + 32'(off);
    else             nxt = model_pc + 32'd4;
    model_pc = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  initial begin
    rst = 1'b1; br_en = 1'b0; alu_zero = 1'b0; jmp_en = 1'b0;
    imm16 = '0; jtarget = '0;
    model_pc = '0;
    drive_reset("R1");
    drive(0, 0, 0, 16'h0000, 26'h0, "R2");
    drive(0, 0, 0, 16'hFFFF, 26'h3FFFFFF, "R2");
    drive(0, 1, 0, 16'h0040, 26'h0, "R5");
    drive(1, 0, 0, 16'h0040, 26'h0, "R4");
    drive(1, 1, 0, 16'h0010, 26'h0, "R3");   // forward
    drive(1, 1, 0, 16'hFFF8, 26'h0, "R3");   // backward
    drive(1, 1, 0, 16'h7FFF, 26'h0, "R3");   // largest forward
    drive(0, 1, 0, 16'h8000, 26'h0, "R5");
    drive(0, 0, 1, 16'h0000, 26'h0123456, "R6");
    drive(1, 1, 1, 16'h0100, 26'h00000AB, "R7");
    drive(1, 0, 1, 16'h0100, 26'h1000000, "R6");
    drive_reset("R1");
    drive(1, 1, 0, 16'hFFFE, 26'h0, "R9");   // 0 + 4 - 8 wraps to top
    drive(0, 0, 1, 16'h0000, 26'h3FFFFFF, "R6"); // region F kept
    drive(0, 0, 0, 16'h0000, 26'h0, "R9");   // 0xFFFFFFFC + 4 wraps to 0
    drive(1, 1, 0, 16'h8000, 26'h0, "R9");   // most negative offset wraps
    drive(0, 0, 0, 16'h0000, 26'h0, "R2");
    drive(1, 0, 0, 16'hFFFF, 26'h0, "R4");
    drive_reset("R1");
    drive(0, 0, 0, 16'h0000, 26'h0, "R2");
    @(negedge clk);
    br_en = 1'b0; alu_zero = 1'b0; jmp_en = 1'b0;
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R1-chain actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule